// File: doc/BRIEF.md
# Banked Partial-Sum Accumulator

This block is one bank of the store that gathers convolution partial sums across input-channel passes. Partial sums arrive one signed 16-bit value at a time. The bank groups every four accepted values into a 64-bit word and adds that word, lane by lane, to the word already held at the same address of a 4096-entry memory. The result is written back, so each pass over an input channel adds onto the sums left by the passes before it.

A pulse on the pass-start input begins a new pass at address zero. The first-pass flag is sampled with that pulse and makes the whole pass overwrite the memory instead of adding to it. Each lane addition is clamped to the signed 16-bit range. The read-modify-write is split over cycles: the stored word is fetched as soon as the first value of a word arrives, and the sum is written back in the cycle after the word completes. A separate read port lets a consumer drain the finished sums.

A full unit places one such bank beside each processing-element group, so all groups can keep streaming results at full rate.

Top module: `psum_bank_acc`

## Requirements
- R1: After reset, `rd_data` reads as zero until the first read request.
- R2: Four consecutive accepted values form one word. The first value goes into bits 15:0, the second into 31:16, the third into 47:32 and the fourth into 63:48.
- R3: A cycle with `in_valid` low and `pass_start` low does not advance the packing position.
- R4: The first completed word of a pass goes to address 0. Each further completed word goes to the next higher address.
- R5: While the flag captured at pass start is 1, each completed word is stored unchanged, whatever the memory held before.
- R6: While that flag is 0, each lane of a completed word is added to the same lane of the word stored at its address, and the sum is written back.
- R7: Each lane sum saturates: it becomes 0x7FFF above 32767 and 0x8000 below -32768.
- R8: A word that starts in the cycle right after a word to the same address completed uses the newly summed value, not the older stored one.
- R9: A `pass_start` pulse drops any partly packed word. The dropped values cause no write, and the sample taken in the same cycle, if valid, becomes lane 0 of address 0.
- R10: `rd_data` shows the word stored at `rd_addr` one cycle after `rd_en`, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_start | input | 1 | Begins a new pass at address 0 |
| first_pass | input | 1 | Sampled with pass_start; 1 = overwrite instead of accumulate |
| in_valid | input | 1 | in_data holds a partial sum |
| in_data | input | 16 | Signed partial sum |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| rd_data | output | 64 | Registered read data, four signed 16-bit lanes |

## Verification
A word lands in memory on the second rising edge after its fourth value is sampled: one edge captures the sum and the next writes it. A read returns its data on the first edge after `rd_en`. The bench therefore keeps at least three idle cycles between the last completed word and any read. It compares `rd_data` on every falling edge with a behavioural model that updates as the edges occur. The saturation and forwarding cases are also checked against hand-computed words.

// File: rtl/psum_bank_acc.sv
module psum_bank_acc #(
  parameter int W      = 16,
  parameter int LANES  = 4,
  parameter int DEPTH  = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pass_start,
  input  logic                 first_pass,
  input  logic                 in_valid,
  input  logic [W-1:0]         in_data,
  input  logic                 rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [W*LANES-1:0]   rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int DW = W * LANES;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [DW-1:0] mem [DEPTH];

  logic [LW-1:0]       lane_q;
  logic [AW-1:0]       fill_addr_q;
  logic                first_q, wfirst_q;
  logic [DW-W-1:0]     pack_q;
  logic [DW-1:0]       old_q;
  logic                wr_en_q;
  logic [AW-1:0]       wr_addr_q;
  logic [DW-1:0]       wr_data_q;

  logic [LW-1:0] lane_eff;
  logic [AW-1:0] addr_eff;
  logic          first_eff, word_start, word_done;
  logic [DW-1:0] new_word, sum_word;

  assign lane_eff   = pass_start ? '0 : lane_q;
  assign addr_eff   = pass_start ? '0 : fill_addr_q;
  assign first_eff  = pass_start ? first_pass : first_q;
  assign word_start = in_valid && (lane_eff == '0);
  assign word_done  = in_valid && (lane_eff == LW'(LANES-1));
  assign new_word   = {in_data, pack_q};

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic signed [W:0] raw;
      assign raw = $signed({old_q[k*W+W-1], old_q[k*W +: W]})
                 + $signed({new_word[k*W+W-1], new_word[k*W +: W]});
      assign sum_word[k*W +: W] = wfirst_q ? new_word[k*W +: W]
                                : (raw[W] != raw[W-1]) ? (raw[W] ? SMIN : SMAX)
                                : raw[W-1:0];
    end
    for (genvar k = 0; k < LANES-1; k++) begin : g_pack
      always_ff @(posedge clk)
        if (in_valid && lane_eff == LW'(k)) pack_q[k*W +: W] <= in_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q      <= '0;
      fill_addr_q <= '0;
      first_q     <= 1'b0;
      wfirst_q    <= 1'b0;
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      rd_data     <= '0;
    end else begin
      if (pass_start) first_q <= first_pass;
      if (in_valid) lane_q <= word_done ? '0 : lane_eff + LW'(1);
      else if (pass_start) lane_q <= '0;
      if (word_done) fill_addr_q <= addr_eff + AW'(1);
      else if (pass_start) fill_addr_q <= '0;
      if (word_start) wfirst_q <= first_eff;
      wr_en_q <= word_done;
      if (word_done) begin
        wr_addr_q <= addr_eff;
        wr_data_q <= sum_word;
      end
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_q) mem[wr_addr_q] <= wr_data_q;
    if (word_start)
      old_q <= (wr_en_q && wr_addr_q == addr_eff) ? wr_data_q : mem[addr_eff];
  end
endmodule

// File: rtl/psum_bank_acc_chk.sv
module psum_bank_acc_chk #(
  parameter int AW = 12,
  parameter int LW = 2,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pass_start,
  input logic          in_valid,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [LW-1:0] lane_q,
  input logic [AW-1:0] fill_addr_q,
  input logic [AW-1:0] addr_eff,
  input logic          word_start,
  input logic          word_done,
  input logic          wr_en_q,
  input logic [AW-1:0] wr_addr_q,
  input logic [DW-1:0] wr_data_q,
  input logic [DW-1:0] old_q
);
  assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !pass_start) |=> $stable(lane_q));
  assert_addr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_start && !word_done) |=> fill_addr_q == '0);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> fill_addr_q == $past(addr_eff) + AW'(1));
  assert_write_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> wr_en_q);
  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> !wr_en_q);
  assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && wr_en_q && wr_addr_q == addr_eff) |=> old_q == $past(wr_data_q));
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind psum_bank_acc psum_bank_acc_chk #(.AW(AW), .LW(LW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .in_valid(in_valid),
  .rd_en(rd_en), .rd_data(rd_data), .lane_q(lane_q), .fill_addr_q(fill_addr_q),
  .addr_eff(addr_eff), .word_start(word_start), .word_done(word_done),
  .wr_en_q(wr_en_q), .wr_addr_q(wr_addr_q), .wr_data_q(wr_data_q), .old_q(old_q)
);

// File: tb/psum_bank_acc_test.sv
module psum_bank_acc_test;
  logic clk = 0, rst_n = 0;
  logic pass_start = 0, first_pass = 0, in_valid = 0, rd_en = 0;
  logic [15:0] in_data = '0;
  logic [11:0] rd_addr = '0;
  logic [63:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  psum_bank_acc uut (.*);

  always #5 clk = ~clk;

  // behavioural reference model
  logic [63:0] m_mem [int];
  int m_lane = 0, m_addr = 0;
  bit m_first = 0, m_wfirst = 0;
  int m_pack [4];
  logic [63:0] exp_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lane = 0; m_addr = 0; m_first = 0; exp_rd = '0;
    end else begin
      if (rd_en) exp_rd = m_mem.exists(int'(rd_addr)) ? m_mem[int'(rd_addr)] : 'x;
      if (pass_start) begin m_lane = 0; m_addr = 0; m_first = first_pass; end
      if (in_valid) begin
        if (m_lane == 0) m_wfirst = m_first;
        m_pack[m_lane] = int'($signed(in_data));
        if (m_lane == 3) begin
          logic [63:0] w;
          for (int k = 0; k < 4; k++) begin
            int s;
            s = m_pack[k];
            if (!m_wfirst) begin
              s += int'($signed(m_mem[m_addr][k*16 +: 16]));
              if (s > 32767) s = 32767;
              if (s < -32768) s = -32768;
            end
            w[k*16 +: 16] = 16'(s);
          end
          m_mem[m_addr] = w;
          m_addr = (m_addr + 1) % 4096;
          m_lane = 0;
        end else m_lane++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done && !$isunknown(exp_rd)) begin
    n_chk++;
    if (rd_data !== exp_rd) begin
      n_fail++;
      $display("FAIL R10 model compare: rd_data=%h expected=%h", rd_data, exp_rd);
    end
  end

  task automatic put(input logic [15:0] v, input bit st = 0, input bit fp = 0);
    pass_start = st; first_pass = fp; in_valid = 1; in_data = v;
    @(negedge clk);
    pass_start = 0; in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_word(input logic [11:0] a, input logic [63:0] e, input string tag);
    idle(3);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    n_chk++;
    if (rd_data !== e) begin
      n_fail++;
      $display("FAIL %s addr %0d: rd_data=%h expected=%h", tag, a, rd_data, e);
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (rd_data !== '0) begin
      n_fail++; $display("FAIL R1 reset: rd_data=%h expected=0", rd_data);
    end

    // R2 R3 R4 R5: first pass with gaps
    put(1, 1, 1); idle(2); put(2); put(3); idle(1); put(4);
    put(5); idle(3); put(6); put(7); put(8);
    check_word(0, 64'h0004_0003_0002_0001, "R2/R5 pack first pass");
    check_word(1, 64'h0008_0007_0006_0005, "R4 address step");
    // R10 hold while rd_en low
    idle(2); n_chk++;
    if (rd_data !== 64'h0008_0007_0006_0005) begin
      n_fail++; $display("FAIL R10 hold: rd_data=%h expected=%h", rd_data, 64'h0008_0007_0006_0005);
    end

    // R6 accumulate
    put(11, 1, 0); put(12); put(13); put(14);
    put(15); put(16); put(17); put(18);
    check_word(0, 64'h0012_0010_000E_000C, "R6 accumulate");
    check_word(1, 64'h001A_0018_0016_0014, "R6 accumulate second word");

    // R7 saturation
    put(16'h7000, 1, 1); put(16'h9000); put(16'h0001); put(16'hFFFF);
    idle(2);
    put(16'h2000, 1, 0); put(16'h9000); put(16'h7FFF); put(16'h0001);
    check_word(0, 64'h0000_7FFF_8000_7FFF, "R7 saturation");

    // R8 back-to-back same address
    put(1, 1, 1); put(1); put(1); put(1);
    put(2, 1, 0); put(2); put(2); put(2);
    put(3, 1, 0); put(3); put(3); put(3);
    check_word(0, 64'h0006_0006_0006_0006, "R8 forwarding");

    // R9 partial word dropped
    put(16'h55, 1, 1); put(16'h66);
    put(9, 1, 1); put(8); put(7); put(6);
    check_word(0, 64'h0006_0007_0008_0009, "R9 restart lane 0");
    check_word(1, 64'h001A_0018_0016_0014, "R9 no stray write");
    check_word(0, 64'h0006_0007_0008_0009, "R10 read latency");

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule